// File: doc/BRIEF.md
# Interlaced Video Sync Timing Core

This block keeps the horizontal and vertical timing of a 525-line or 625-line interlaced picture. It runs on the double-rate pixel clock and has one pair of position counters: pixel position within a line and line number within a frame. In master operation the counters run freely. The block shapes active-low horizontal and vertical sync from them, turns on a single output-enable for the sync pads, and reports pixel, line and field.

In slave operation the same counters follow external active-low sync inputs. A horizontal sync falling edge restarts the pixel count. A vertical sync falling edge loads the line count and sets the field. The field is decided by how close the vertical edge lands to the most recent horizontal edge. A two-bit standard select picks 525-line timing, 625-line timing or sleep. Sleep parks the counters and releases the sync outputs.

The sync inputs are expected to be already in the double-rate clock domain. Every pin is a plain level. There is no data stream and no handshake.

Top module: `vse_sync_core`

## Requirements
- R1: `mode_i` encodes the standard: 2'b11 and 2'b01 select 525-line timing with lines of `LINE_LEN_525` clocks; 2'b10 selects 625-line timing with lines of `LINE_LEN_625` clocks; 2'b00 selects sleep.
- R2: After reset, with master operation selected, `pix_o` and `line_o` read 0. `pix_o` then advances by one each clock and wraps after the line length. `line_o` advances on each pixel wrap and wraps after `LINES_525` or `LINES_625` lines.
- R3: In master operation `hsync_n_o` is low exactly while `pix_o` is below `HS_WIDTH`, which gives a low pulse of `HS_WIDTH` clocks per line.
- R4: In master operation `vsync_n_o` is low for the first `VS_LINES` whole lines of the frame (lines 0 up to `VS_LINES`-1), so it falls together with horizontal sync.
- R5: The second field's vertical sync falls at line M = (lines-1)/2, pixel H = line length/2, and stays low for `VS_LINES` lines. In master operation `field_o` is 1 from that point to the end of the frame and 0 before it.
- R6: In sleep, `pix_o`, `line_o` and `field_o` read 0 from the next clock on. Both sync outputs read 1 and `sync_oe_o` reads 0. On leaving sleep the count restarts from pixel 0, line 0.
- R7: `sync_oe_o` is 1 only in master operation outside sleep. While it is 0, both sync outputs read 1.
- R8: In slave operation the pixel counter reads 0 in the clock after the edge at which `hsync_n_i` is first sampled low. With no such edge it runs freely as in R2.
- R9: In slave operation a `vsync_n_i` falling edge counts as the first field when the pixel count it would move to is below `HS_WIDTH`. The line count then reads 0 and `field_o` reads 0 in the next clock.
- R10: In slave operation a `vsync_n_i` falling edge any later in the line counts as the second field. The line count then reads M and `field_o` reads 1 in the next clock, and the pixel count carries on.
- R11: In slave operation each `hsync_n_i` falling edge advances the line count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate pixel clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Standard select (R1 encoding) |
| master_i | input | 1 | 1: block drives sync; 0: block follows sync inputs |
| hsync_n_i | input | 1 | External horizontal sync, active low (slave) |
| vsync_n_i | input | 1 | External vertical sync, active low (slave) |
| hsync_n_o | output | 1 | Generated horizontal sync, active low |
| vsync_n_o | output | 1 | Generated vertical sync, active low |
| sync_oe_o | output | 1 | Drive enable for the sync pads |
| pix_o | output | PXW | Pixel position in the line, in double-rate clocks |
| line_o | output | LNW | Line number in the frame, from 0 |
| field_o | output | 1 | 0: first field, 1: second field |

## Verification
The sync outputs and the field flag in master operation are decoded without a register from the counters. They therefore change in the same clock as the position they describe, and the k-th clock after reset release shows pixel k mod line length. Slave edges and sleep act through one register stage, so their results appear one clock after the edge that samples the stimulus. The bench drives stimulus on the falling clock edge. It samples one nanosecond after a falling edge and counts exactly how many rising edges lie between the two, so each expected value is taken from the cycle count alone. Small line lengths and line counts keep a whole frame of every standard inside the run, and every clock of it is compared.

// File: rtl/vse_pkg.sv
package vse_pkg;
  typedef enum logic [1:0] {
    STD_SLEEP = 2'b00,
    STD_PALM  = 2'b01,
    STD_PAL   = 2'b10,
    STD_NTSC  = 2'b11
  } vse_std_e;
endpackage

// File: rtl/vse_std_decode.sv
module vse_std_decode #(
  parameter int LEN_A  = 1716,
  parameter int LEN_B  = 1728,
  parameter int ROWS_A = 525,
  parameter int ROWS_B = 625,
  parameter int PXW    = 11,
  parameter int LNW    = 10
) (
  input  logic [1:0]     mode_i,
  output logic           sleep_o,
  output logic [PXW-1:0] len_o,
  output logic [PXW-1:0] half_o,
  output logic [LNW-1:0] rows_o,
  output logic [LNW-1:0] mid_o
);
  import vse_pkg::*;

  localparam logic [PXW-1:0] LenA  = PXW'(LEN_A);
  localparam logic [PXW-1:0] LenB  = PXW'(LEN_B);
  localparam logic [PXW-1:0] HalfA = PXW'(LEN_A / 2);
  localparam logic [PXW-1:0] HalfB = PXW'(LEN_B / 2);
  localparam logic [LNW-1:0] RowsA = LNW'(ROWS_A);
  localparam logic [LNW-1:0] RowsB = LNW'(ROWS_B);
  localparam logic [LNW-1:0] MidA  = LNW'((ROWS_A - 1) / 2);
  localparam logic [LNW-1:0] MidB  = LNW'((ROWS_B - 1) / 2);

  vse_std_e std;
  assign std = vse_std_e'(mode_i);

  // 525-line geometry is the fallback; sleep keeps it but flags the park
  always_comb begin
    sleep_o = 1'b0;
    len_o   = LenA;
    half_o  = HalfA;
    rows_o  = RowsA;
    mid_o   = MidA;
    case (std)
      STD_PAL: begin
        len_o  = LenB;
        half_o = HalfB;
        rows_o = RowsB;
        mid_o  = MidB;
      end
      STD_SLEEP: sleep_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/vse_fall_detect.sv
module vse_fall_detect #(
  parameter int CH = 2
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic [CH-1:0] sig_n_i,
  output logic [CH-1:0] fall_o
);
  logic [CH-1:0] prev_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) prev_q[c] <= 1'b1;
      else          prev_q[c] <= sig_n_i[c];
    end
    assign fall_o[c] = prev_q[c] & ~sig_n_i[c];
  end
endmodule

// File: rtl/vse_pos_counter.sv
module vse_pos_counter #(
  parameter int PXW = 11,
  parameter int LNW = 10
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           clr_i,
  input  logic           hs_sync_i,
  input  logic           vs_load_i,
  input  logic [LNW-1:0] vs_row_i,
  input  logic [PXW-1:0] len_i,
  input  logic [LNW-1:0] rows_i,
  output logic [PXW-1:0] px_o,
  output logic [LNW-1:0] row_o,
  output logic [PXW-1:0] px_next_o
);
  logic [PXW-1:0] px_q;
  logic [LNW-1:0] row_q, row_d;
  logic           px_last, line_step;

  assign px_last   = px_q >= (len_i - PXW'(1));
  assign line_step = hs_sync_i | px_last;
  assign px_next_o = line_step ? '0 : px_q + PXW'(1);

  always_comb begin
    row_d = row_q;
    if (vs_load_i)
      row_d = vs_row_i;
    else if (line_step)
      row_d = (row_q >= rows_i - LNW'(1)) ? '0 : row_q + LNW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      px_q  <= '0;
      row_q <= '0;
    end else if (clr_i) begin
      px_q  <= '0;
      row_q <= '0;
    end else begin
      px_q  <= px_next_o;
      row_q <= row_d;
    end
  end

  assign px_o  = px_q;
  assign row_o = row_q;
endmodule

// File: rtl/vse_sync_shaper.sv
module vse_sync_shaper #(
  parameter int PXW      = 11,
  parameter int LNW      = 10,
  parameter int HS_WIDTH = 64,
  parameter int VS_LINES = 2
) (
  input  logic           act_i,
  input  logic [PXW-1:0] px_i,
  input  logic [LNW-1:0] row_i,
  input  logic [PXW-1:0] half_i,
  input  logic [LNW-1:0] mid_i,
  output logic           hs_n_o,
  output logic           vs_n_o,
  output logic           field_o
);
  localparam logic [PXW-1:0] HsW = PXW'(HS_WIDTH);
  localparam logic [LNW-1:0] VsL = LNW'(VS_LINES);

  logic [LNW-1:0] even_end;
  logic odd_win, after_start, before_end;

  assign even_end    = mid_i + VsL;
  assign odd_win     = row_i < VsL;
  assign after_start = (row_i > mid_i) || ((row_i == mid_i) && (px_i >= half_i));
  assign before_end  = (row_i < even_end) || ((row_i == even_end) && (px_i < half_i));

  assign hs_n_o  = ~(act_i && (px_i < HsW));
  assign vs_n_o  = ~(act_i && (odd_win || (after_start && before_end)));
  assign field_o = after_start;
endmodule

// File: rtl/vse_sync_core.sv
module vse_sync_core #(
  parameter int LINE_LEN_525 = 1716,
  parameter int LINE_LEN_625 = 1728,
  parameter int LINES_525    = 525,
  parameter int LINES_625    = 625,
  parameter int HS_WIDTH     = 64,
  parameter int VS_LINES     = 2,
  localparam int LEN_MAX  = (LINE_LEN_625 > LINE_LEN_525) ? LINE_LEN_625 : LINE_LEN_525,
  localparam int ROWS_MAX = (LINES_625 > LINES_525) ? LINES_625 : LINES_525,
  localparam int PXW      = $clog2(LEN_MAX),
  localparam int LNW      = $clog2(ROWS_MAX)
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic [1:0]     mode_i,
  input  logic           master_i,
  input  logic           hsync_n_i,
  input  logic           vsync_n_i,
  output logic           hsync_n_o,
  output logic           vsync_n_o,
  output logic           sync_oe_o,
  output logic [PXW-1:0] pix_o,
  output logic [LNW-1:0] line_o,
  output logic           field_o
);
  localparam logic [PXW-1:0] HsW = PXW'(HS_WIDTH);

  logic           sleep;
  logic [PXW-1:0] len, half, px_next;
  logic [LNW-1:0] rows, mid, vs_row;
  logic [1:0]     fall;
  logic           m_act, s_act, hs_sync, vs_load, odd_hit;
  logic           gen_field, field_q;

  vse_std_decode #(
    .LEN_A(LINE_LEN_525), .LEN_B(LINE_LEN_625),
    .ROWS_A(LINES_525), .ROWS_B(LINES_625), .PXW(PXW), .LNW(LNW)
  ) u_decode (
    .mode_i(mode_i), .sleep_o(sleep), .len_o(len), .half_o(half),
    .rows_o(rows), .mid_o(mid)
  );

  vse_fall_detect #(.CH(2)) u_edges (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .sig_n_i({vsync_n_i, hsync_n_i}), .fall_o(fall)
  );

  assign m_act   = master_i & ~sleep;
  assign s_act   = ~master_i & ~sleep;
  assign hs_sync = s_act & fall[0];
  assign vs_load = s_act & fall[1];
  // field identity comes from where in the line the vertical edge lands
  assign odd_hit = px_next < HsW;
  assign vs_row  = odd_hit ? '0 : mid;

  vse_pos_counter #(.PXW(PXW), .LNW(LNW)) u_count (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(sleep),
    .hs_sync_i(hs_sync), .vs_load_i(vs_load), .vs_row_i(vs_row),
    .len_i(len), .rows_i(rows),
    .px_o(pix_o), .row_o(line_o), .px_next_o(px_next)
  );

  vse_sync_shaper #(
    .PXW(PXW), .LNW(LNW), .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES)
  ) u_shape (
    .act_i(m_act), .px_i(pix_o), .row_i(line_o), .half_i(half), .mid_i(mid),
    .hs_n_o(hsync_n_o), .vs_n_o(vsync_n_o), .field_o(gen_field)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     field_q <= 1'b0;
    else if (sleep)   field_q <= 1'b0;
    else if (vs_load) field_q <= ~odd_hit;
  end

  assign sync_oe_o = m_act;
  assign field_o   = master_i ? gen_field : field_q;
endmodule

// File: rtl/vse_sync_checker.sv
module vse_sync_checker #(
  parameter int LINE_LEN_525 = 1716,
  parameter int LINE_LEN_625 = 1728,
  parameter int LINES_525    = 525,
  parameter int LINES_625    = 625,
  parameter int HS_WIDTH     = 64,
  parameter int VS_LINES     = 2,
  localparam int LEN_MAX  = (LINE_LEN_625 > LINE_LEN_525) ? LINE_LEN_625 : LINE_LEN_525,
  localparam int ROWS_MAX = (LINES_625 > LINES_525) ? LINES_625 : LINES_525,
  localparam int PXW      = $clog2(LEN_MAX),
  localparam int LNW      = $clog2(ROWS_MAX),
  localparam int CW       = $clog2(HS_WIDTH + 2)
) (
  input logic           clk_i,
  input logic           rst_n_i,
  input logic [1:0]     mode_i,
  input logic           master_i,
  input logic           hsync_n_i,
  input logic           vsync_n_i,
  input logic           hsync_n_o,
  input logic           vsync_n_o,
  input logic           sync_oe_o,
  input logic [PXW-1:0] pix_o,
  input logic [LNW-1:0] line_o,
  input logic           field_o
);
  logic           act, sl;
  logic [PXW-1:0] len_c, half_c;
  logic [LNW-1:0] rows_c;
  logic [CW-1:0]  hs_cnt;

  assign act    = master_i && (mode_i != 2'b00);
  assign sl     = !master_i && (mode_i != 2'b00);
  assign len_c  = (mode_i == 2'b10) ? PXW'(LINE_LEN_625) : PXW'(LINE_LEN_525);
  assign half_c = len_c >> 1;
  assign rows_c = (mode_i == 2'b10) ? LNW'(LINES_625) : LNW'(LINES_525);

  // length of the current or just-ended low run of the generated hsync
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        hs_cnt <= '0;
    else if (!act)       hs_cnt <= '0;
    else if (!hsync_n_o) hs_cnt <= (hs_cnt == CW'(HS_WIDTH + 1)) ? hs_cnt : hs_cnt + CW'(1);
    else                 hs_cnt <= '0;
  end

  assert_hs_width_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act && hsync_n_o && hs_cnt != '0) |-> (hs_cnt == CW'(HS_WIDTH)));

  assert_hs_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act && !hsync_n_o) |-> (hs_cnt < CW'(HS_WIDTH)));

  assert_pix_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act && pix_o == len_c - PXW'(1)) |=> (pix_o == '0));

  assert_line_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act && pix_o == len_c - PXW'(1) && line_o == rows_c - LNW'(1)) |=> (line_o == '0));

  assert_vs_start_R4_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act && $past(act) && $stable(mode_i) && $fell(vsync_n_o)) |->
      ((!hsync_n_o && line_o == '0 && pix_o == '0) || (field_o && pix_o == half_c)));

  assert_sleep_park_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i == 2'b00) |=> (pix_o == '0 && line_o == '0 && !field_o));

  assert_slave_release_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !master_i |-> (!sync_oe_o && hsync_n_o && vsync_n_o));

  assert_odd_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sl && $fell(hsync_n_i) && $fell(vsync_n_i)) |=>
      (line_o == '0 && pix_o == '0 && !field_o));

  assert_field_line_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sl && $fell(vsync_n_i)) |=> (master_i || (field_o == (line_o != '0))));
endmodule

bind vse_sync_core vse_sync_checker #(
  .LINE_LEN_525(LINE_LEN_525), .LINE_LEN_625(LINE_LEN_625),
  .LINES_525(LINES_525), .LINES_625(LINES_625),
  .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES)
) u_sync_chk (.*);

// File: tb/vse_sync_core_tb_top.sv
`timescale 1ns/1ps
module vse_sync_core_tb_top;
  localparam int L525 = 40;
  localparam int L625 = 48;
  localparam int N525 = 11;
  localparam int N625 = 13;
  localparam int HSW  = 6;
  localparam int VSL  = 2;
  localparam int PXW  = $clog2(L625);
  localparam int LNW  = $clog2(N625);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic master = 1'b1;
  logic hs_in = 1'b1;
  logic vs_in = 1'b1;
  logic hs_out, vs_out, oe, field;
  logic [PXW-1:0] pix;
  logic [LNW-1:0] line;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vse_sync_core #(
    .LINE_LEN_525(L525), .LINE_LEN_625(L625), .LINES_525(N525), .LINES_625(N625),
    .HS_WIDTH(HSW), .VS_LINES(VSL)
  ) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .master_i(master),
    .hsync_n_i(hs_in), .vsync_n_i(vs_in), .hsync_n_o(hs_out), .vsync_n_o(vs_out),
    .sync_oe_o(oe), .pix_o(pix), .line_o(line), .field_o(field)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // whole-frame sweep of one master standard, one compare set per clock
  task automatic sweep(input logic [1:0] m);
    int len, rows, half, mid, p, l;
    bit odd, aft, bef;
    len  = (m == 2'b10) ? L625 : L525;
    rows = (m == 2'b10) ? N625 : N525;
    half = len / 2;
    mid  = (rows - 1) / 2;
    mode = m;
    master = 1'b1;
    do_reset();
    for (int k = 0; k < len * rows + len; k++) begin
      #1;
      p = k % len;
      l = (k / len) % rows;
      odd = l < VSL;
      aft = (l > mid) || (l == mid && p >= half);
      bef = (l < mid + VSL) || (l == mid + VSL && p < half);
      chk("R1 pixel position", int'(pix), p);
      chk("R2 line number", int'(line), l);
      chk("R3 hsync level", int'(hs_out), (p < HSW) ? 0 : 1);
      chk("R4 R5 vsync level", int'(vs_out), (odd || (aft && bef)) ? 0 : 1);
      chk("R5 field flag", int'(field), aft ? 1 : 0);
      chk("R7 enable in master", int'(oe), 1);
      @(negedge clk);
    end
  endtask

  // slave: hsync falls at n0, vsync falls d clocks later
  task automatic slave_trial(input int d, input bit even);
    hs_in = 1'b1; vs_in = 1'b1;
    repeat (2) @(negedge clk);
    hs_in = 1'b0;
    if (d == 0) vs_in = 1'b0;
    else begin
      repeat (d) @(negedge clk);
      vs_in = 1'b0;
    end
    @(negedge clk); #1;
    chk(even ? "R10 line after late vsync" : "R9 line after early vsync", int'(line), even ? (N525 - 1) / 2 : 0);
    chk(even ? "R10 field after late vsync" : "R9 field after early vsync", int'(field), even ? 1 : 0);
    chk(even ? "R10 pixel carries on" : "R9 pixel position", int'(pix), d);
    hs_in = 1'b1; vs_in = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    // reset state
    do_reset();
    #1;
    chk("R2 reset pixel", int'(pix), 0);
    chk("R2 reset line", int'(line), 0);

    sweep(2'b11);
    sweep(2'b10);
    sweep(2'b01);

    // sleep park and restart
    mode = 2'b00;
    repeat (2) @(negedge clk); #1;
    chk("R6 sleep pixel", int'(pix), 0);
    chk("R6 sleep line", int'(line), 0);
    chk("R6 sleep field", int'(field), 0);
    chk("R6 sleep hsync", int'(hs_out), 1);
    chk("R6 sleep vsync", int'(vs_out), 1);
    chk("R6 R7 sleep enable", int'(oe), 0);
    repeat (5) @(negedge clk); #1;
    chk("R6 still parked", int'(pix), 0);
    @(negedge clk);
    mode = 2'b11; #1;
    chk("R6 restart pixel", int'(pix), 0);
    chk("R6 restart hsync", int'(hs_out), 0);
    @(negedge clk); #1;
    chk("R6 restart advance", int'(pix), 1);

    // slave operation
    master = 1'b0;
    mode = 2'b11;
    do_reset();
    #1;
    chk("R7 slave enable", int'(oe), 0);
    chk("R7 slave hsync out", int'(hs_out), 1);
    chk("R7 slave vsync out", int'(vs_out), 1);
    repeat (5) @(negedge clk); #1;
    chk("R8 freewheel pixel", int'(pix), 5);

    slave_trial(0, 1'b0);
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk); #1;
      chk("R8 pixel after hsync edge", int'(pix), j);
    end
    hs_in = 1'b0;
    @(negedge clk); #1;
    chk("R8 pixel restart", int'(pix), 0);
    chk("R11 line advance", int'(line), 1);
    hs_in = 1'b1;
    @(negedge clk);
    hs_in = 1'b0;
    @(negedge clk); #1;
    chk("R11 second line advance", int'(line), 2);
    hs_in = 1'b1;

    slave_trial(HSW - 1, 1'b0);
    slave_trial(HSW, 1'b1);
    slave_trial(20, 1'b1);
    slave_trial(1, 1'b0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule